// File: doc/BRIEF.md
# Processor Bus Status Command Decoder

This block sits beside a processor that reports each bus cycle only as a three-bit status code. It watches that code and, on the processor's clock, produces the system command strobes: memory read, memory write, I/O read, I/O write and interrupt acknowledge. It also produces early versions of both write strobes, and the address-strobe, data-enable and data-direction controls that the processor leaves undriven in this operating mode.

The status idles at all-ones. A cycle begins at the first clock edge where the status shows any other value. The decoder latches the code at that edge and steps through an address phase, a first command phase and a held command phase. It drops back to idle at the first edge where the status is all-ones again. Three inputs qualify the command outputs. The command enable blocks all of them. The active-low address enable blocks memory commands, and it also blocks I/O and acknowledge commands unless the I/O-bus select is set.

Top module: `bus_cmd_decoder`

## Requirements
- R1: While the reset input is low, and after it is released, all seven command outputs are high, ale and den are low and dt_r is high until a cycle starts.
- R2: Status codes map to commands as follows: 000 interrupt acknowledge (inta_n), 001 I/O read (iord_n), 010 I/O write (iowr_n/aiowr_n), 100 and 101 memory read (mrd_n), 110 memory write (mwr_n/amwr_n). At most one command family is active in a cycle.
- R3: In idle, the first rising clock edge that samples a status other than 111 starts a cycle. ale is high for exactly the clock that follows that edge, and no command is active during it.
- R4: Memory read, I/O read and interrupt acknowledge go low from the second clock of the cycle until the cycle ends.
- R5: amwr_n and aiowr_n go low from the second clock of a write cycle. mwr_n and iowr_n go low one clock later, from the third clock.
- R6: The first rising edge that samples status 111 during a cycle returns to idle, releasing every command and den by the following clock. This holds even when that edge is the one right after the start.
- R7: A halt cycle (011) raises ale in its first clock, but no command and no den.
- R8: While cmd_en is low, all seven command outputs are high in the same clock, without waiting for an edge.
- R9: While addr_en_n is high, memory commands are held high. I/O commands and inta_n are also held high, unless iob_mode is high, in which case they follow the cycle.
- R10: den is high from the second clock to the end of every non-halt cycle. dt_r is low for the whole of a 000, 001, 100 or 101 cycle, and high at all other times.
- R11: The cycle type is fixed at the start edge. A change of status to another non-passive code during the cycle does not change the commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_i | input | 3 | Cycle status code from the processor |
| addr_en_n | input | 1 | Active-low address enable; high blocks commands per R9 |
| cmd_en | input | 1 | Command enable; low blocks all commands |
| iob_mode | input | 1 | I/O-bus select; lets I/O and acknowledge commands ignore addr_en_n |
| mrd_n | output | 1 | Memory read command, active low |
| mwr_n | output | 1 | Memory write command, active low |
| amwr_n | output | 1 | Early memory write command, active low |
| iord_n | output | 1 | I/O read command, active low |
| iowr_n | output | 1 | I/O write command, active low |
| aiowr_n | output | 1 | Early I/O write command, active low |
| inta_n | output | 1 | Interrupt acknowledge command, active low |
| ale | output | 1 | Address strobe, high for the first clock of a cycle |
| den | output | 1 | Data buffer enable |
| dt_r | output | 1 | Data direction: high transmit, low receive |

## Verification
The bench changes the status on a falling edge. The next rising edge moves the phase register, and the outputs decode from that register without any further stage. So ale is checked at the falling edge one clock after the stimulus, read, acknowledge and early-write strobes one clock later, and normal writes one clock after that. A return to 111 is checked one clock after it is applied. The two gating enables act without a register, so their checks run one time unit after the enable changes, in the middle of a clock. Reset release passes through a two-stage synchronizer, so the first stimulus after reset waits four clocks.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int STAT_W = 3;
  localparam int CMD_N  = 7;

  typedef enum logic [STAT_W-1:0] {
    ST_INTA  = 3'b000,
    ST_IORD  = 3'b001,
    ST_IOWR  = 3'b010,
    ST_HALT  = 3'b011,
    ST_FETCH = 3'b100,
    ST_MRD   = 3'b101,
    ST_MWR   = 3'b110,
    ST_PASS  = 3'b111
  } stat_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_CMD  = 2'd2,
    PH_HOLD = 2'd3
  } phase_e;

  // decoded kind of the latched cycle
  typedef struct packed {
    logic mrd;
    logic mwr;
    logic ior;
    logic iow;
    logic inta;
  } kind_t;

  // command strobes, active high inside the block
  typedef struct packed {
    logic mrd;
    logic mwr;
    logic amw;
    logic ior;
    logic iow;
    logic aiow;
    logic inta;
  } cmd_t;
endpackage

// File: rtl/bcd_rst_sync.sv
module bcd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int NS = (STAGES < 1) ? 1 : STAGES;

  logic [NS-1:0] chain_q;
  logic [NS-1:0] chain_d;

  always_comb begin
    chain_d[0] = 1'b1;
    for (int i = 1; i < NS; i++) chain_d[i] = chain_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[NS-1];
endmodule

// File: rtl/bcd_seq.sv
module bcd_seq
  import bcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] stat_i,
  output phase_e            phase,
  output logic [STAT_W-1:0] code_q
);
  phase_e            phase_q, phase_d;
  logic [STAT_W-1:0] code_d;
  logic              code_en;
  logic              passive;

  assign passive = (stat_i == ST_PASS);

  always_comb begin
    phase_d = phase_q;
    code_d  = code_q;
    code_en = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (!passive) begin
          phase_d = PH_ADDR;
          code_d  = stat_i;
          code_en = 1'b1;
        end
      end
      PH_ADDR: phase_d = passive ? PH_IDLE : PH_CMD;
      PH_CMD:  phase_d = passive ? PH_IDLE : PH_HOLD;
      PH_HOLD: phase_d = passive ? PH_IDLE : PH_HOLD;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= ST_PASS;
    else if (code_en) code_q <= code_d;
  end

  assign phase = phase_q;
endmodule

// File: rtl/bcd_decode.sv
module bcd_decode
  import bcd_pkg::*;
(
  input  logic [STAT_W-1:0] code,
  output kind_t             kind
);
  always_comb begin
    kind = '0;
    unique case (code)
      ST_INTA:          kind.inta = 1'b1;
      ST_IORD:          kind.ior  = 1'b1;
      ST_IOWR:          kind.iow  = 1'b1;
      ST_FETCH, ST_MRD: kind.mrd  = 1'b1;
      ST_MWR:           kind.mwr  = 1'b1;
      default:          kind      = '0;
    endcase
  end
endmodule

// File: rtl/bcd_cmdgen.sv
module bcd_cmdgen
  import bcd_pkg::*;
(
  input  phase_e phase,
  input  kind_t  kind,
  input  logic   addr_en_n,
  input  logic   cmd_en,
  input  logic   iob_mode,
  output cmd_t   raw,
  output cmd_t   gated,
  output logic   ale,
  output logic   den,
  output logic   dt_r
);
  logic in_cmd;
  logic in_hold;
  logic any_kind;
  logic rx_kind;
  logic mem_ok;
  logic io_ok;

  assign in_cmd   = (phase == PH_CMD) || (phase == PH_HOLD);
  assign in_hold  = (phase == PH_HOLD);
  assign any_kind = |kind;
  assign rx_kind  = kind.mrd | kind.ior | kind.inta;

  always_comb begin
    raw      = '0;
    raw.mrd  = kind.mrd  & in_cmd;
    raw.amw  = kind.mwr  & in_cmd;
    raw.mwr  = kind.mwr  & in_hold;
    raw.ior  = kind.ior  & in_cmd;
    raw.aiow = kind.iow  & in_cmd;
    raw.iow  = kind.iow  & in_hold;
    raw.inta = kind.inta & in_cmd;
  end

  assign mem_ok = cmd_en & ~addr_en_n;
  assign io_ok  = cmd_en & (~addr_en_n | iob_mode);

  always_comb begin
    gated      = '0;
    gated.mrd  = raw.mrd  & mem_ok;
    gated.mwr  = raw.mwr  & mem_ok;
    gated.amw  = raw.amw  & mem_ok;
    gated.ior  = raw.ior  & io_ok;
    gated.iow  = raw.iow  & io_ok;
    gated.aiow = raw.aiow & io_ok;
    gated.inta = raw.inta & io_ok;
  end

  assign ale  = (phase == PH_ADDR);
  assign den  = in_cmd & any_kind;
  assign dt_r = ~((phase != PH_IDLE) & rx_kind);
endmodule

// File: rtl/bus_cmd_decoder.sv
module bus_cmd_decoder
  import bcd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  stat_i,
  input  logic        addr_en_n,
  input  logic        cmd_en,
  input  logic        iob_mode,
  output logic        mrd_n,
  output logic        mwr_n,
  output logic        amwr_n,
  output logic        iord_n,
  output logic        iowr_n,
  output logic        aiowr_n,
  output logic        inta_n,
  output logic        ale,
  output logic        den,
  output logic        dt_r
);
  logic              rst_sync_n;
  phase_e            phase;
  logic [STAT_W-1:0] code_q;
  kind_t             kind;
  cmd_t              raw_cmd;
  cmd_t              gated_cmd;

  bcd_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bcd_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .stat_i (stat_i),
    .phase  (phase),
    .code_q (code_q)
  );

  bcd_decode u_dec (
    .code (code_q),
    .kind (kind)
  );

  bcd_cmdgen u_gen (
    .phase     (phase),
    .kind      (kind),
    .addr_en_n (addr_en_n),
    .cmd_en    (cmd_en),
    .iob_mode  (iob_mode),
    .raw       (raw_cmd),
    .gated     (gated_cmd),
    .ale       (ale),
    .den       (den),
    .dt_r      (dt_r)
  );

  assign mrd_n   = ~gated_cmd.mrd;
  assign mwr_n   = ~gated_cmd.mwr;
  assign amwr_n  = ~gated_cmd.amw;
  assign iord_n  = ~gated_cmd.ior;
  assign iowr_n  = ~gated_cmd.iow;
  assign aiowr_n = ~gated_cmd.aiow;
  assign inta_n  = ~gated_cmd.inta;
endmodule

// File: rtl/bcd_chk.sv
module bcd_chk
  import bcd_pkg::*;
(
  input logic        clk,
  input logic        rst_sync_n,
  input logic        cmd_en,
  input logic [2:0]  stat_i,
  input phase_e      phase,
  input logic [2:0]  code_q,
  input cmd_t        raw_cmd,
  input logic        mrd_n,
  input logic        mwr_n,
  input logic        amwr_n,
  input logic        iord_n,
  input logic        iowr_n,
  input logic        aiowr_n,
  input logic        inta_n,
  input logic        ale,
  input logic        den
);
  AST_CMD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({!mrd_n, !amwr_n, !iord_n, !aiowr_n, !inta_n})); // R2

  AST_ALE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ale |=> !ale); // R3

  AST_NO_CMD_WITH_ALE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ale |-> (raw_cmd == '0)); // R3

  AST_WRITE_AFTER_EARLY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($rose(raw_cmd.mwr) || $rose(raw_cmd.iow)) |-> $past(raw_cmd.amw || raw_cmd.aiow)); // R5

  AST_PASSIVE_ENDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase != PH_IDLE && stat_i == 3'b111) |=> (raw_cmd == '0 && !den)); // R6

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase != PH_IDLE && code_q == 3'b011) |-> (raw_cmd == '0 && !den)); // R7

  AST_CMD_EN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cmd_en |-> (mrd_n && mwr_n && amwr_n && iord_n && iowr_n && aiowr_n && inta_n)); // R8
endmodule

bind bus_cmd_decoder bcd_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .cmd_en     (cmd_en),
  .stat_i     (stat_i),
  .phase      (phase),
  .code_q     (code_q),
  .raw_cmd    (raw_cmd),
  .mrd_n      (mrd_n),
  .mwr_n      (mwr_n),
  .amwr_n     (amwr_n),
  .iord_n     (iord_n),
  .iowr_n     (iowr_n),
  .aiowr_n    (aiowr_n),
  .inta_n     (inta_n),
  .ale        (ale),
  .den        (den)
);

// File: tb/sim_bus_cmd_decoder.sv
module sim_bus_cmd_decoder;
  localparam int CLK_P = 10;
  localparam int NVEC  = 7;

  // {code[17:15], phase2 cmds[14:8], phase3 cmds[7:1], dt_r during cycle[0]}
  // cmd bit order: mrd mwr amw ior iow aiow inta
  localparam logic [17:0] VEC [NVEC] = '{
    {3'b000, 7'b0000001, 7'b0000001, 1'b0},
    {3'b001, 7'b0001000, 7'b0001000, 1'b0},
    {3'b010, 7'b0000010, 7'b0000110, 1'b1},
    {3'b011, 7'b0000000, 7'b0000000, 1'b1},
    {3'b100, 7'b1000000, 7'b1000000, 1'b0},
    {3'b101, 7'b1000000, 7'b1000000, 1'b0},
    {3'b110, 7'b0010000, 7'b0110000, 1'b1}
  };

  logic clk, rst_n, addr_en_n, cmd_en, iob_mode;
  logic [2:0] stat_i;
  logic mrd_n, mwr_n, amwr_n, iord_n, iowr_n, aiowr_n, inta_n, ale, den, dt_r;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  bus_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .stat_i(stat_i), .addr_en_n(addr_en_n),
    .cmd_en(cmd_en), .iob_mode(iob_mode), .mrd_n(mrd_n), .mwr_n(mwr_n),
    .amwr_n(amwr_n), .iord_n(iord_n), .iowr_n(iowr_n), .aiowr_n(aiowr_n),
    .inta_n(inta_n), .ale(ale), .den(den), .dt_r(dt_r)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [6:0] e_cmd,
                     input logic e_ale, input logic e_den, input logic e_dtr);
    logic [6:0] act;
    act = {~mrd_n, ~mwr_n, ~amwr_n, ~iord_n, ~iowr_n, ~aiowr_n, ~inta_n};
    checks++;
    if (act !== e_cmd || ale !== e_ale || den !== e_den || dt_r !== e_dtr) begin
      errors++;
      $display("FAIL %s: cmd=%b ale=%b den=%b dt_r=%b expected cmd=%b ale=%b den=%b dt_r=%b",
               tag, act, ale, den, dt_r, e_cmd, e_ale, e_den, e_dtr);
    end
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; stat_i = 3'b111; addr_en_n = 1'b0; cmd_en = 1'b1; iob_mode = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", 7'b0, 1'b0, 1'b0, 1'b1);
    stat_i = 3'b101;
    step();
    chk("R1 status ignored in reset", 7'b0, 1'b0, 1'b0, 1'b1);
    stat_i = 3'b111;
    rst_n = 1'b1;
    repeat (4) step();
    chk("R1 after release", 7'b0, 1'b0, 1'b0, 1'b1);

    // table walk: one full cycle per status code
    for (int i = 0; i < NVEC; i++) begin
      logic [2:0] c;
      logic [6:0] p2, p3;
      logic dtr, dn;
      c = VEC[i][17:15]; p2 = VEC[i][14:8]; p3 = VEC[i][7:1]; dtr = VEC[i][0];
      dn = (c != 3'b011);
      stat_i = c;
      step();
      chk($sformatf("R3 R7 R10 first clock code %b", c), 7'b0, 1'b1, 1'b0, dtr);
      step();
      chk($sformatf("R2 R4 R5 R10 second clock code %b", c), p2, 1'b0, dn, dtr);
      step();
      chk($sformatf("R2 R5 R7 third clock code %b", c), p3, 1'b0, dn, dtr);
      stat_i = 3'b111;
      step();
      chk($sformatf("R6 end code %b", c), 7'b0, 1'b0, 1'b0, 1'b1);
    end

    // R8: command enable acts inside the clock
    stat_i = 3'b101; step(); step();
    cmd_en = 1'b0; #1;
    chk("R8 cmd_en low blocks read", 7'b0, 1'b0, 1'b1, 1'b0);
    cmd_en = 1'b1; #1;
    chk("R8 cmd_en restored", 7'b1000000, 1'b0, 1'b1, 1'b0);
    @(negedge clk); stat_i = 3'b111; step();

    // R9: address enable gating and I/O-bus select
    addr_en_n = 1'b1;
    stat_i = 3'b110; step(); step(); step();
    chk("R9 memory write blocked", 7'b0, 1'b0, 1'b1, 1'b1);
    stat_i = 3'b111; step();
    iob_mode = 1'b1;
    stat_i = 3'b001; step(); step();
    chk("R9 io read passes in io-bus mode", 7'b0001000, 1'b0, 1'b1, 1'b0);
    stat_i = 3'b111; step();
    stat_i = 3'b101; step(); step();
    chk("R9 memory read still blocked", 7'b0, 1'b0, 1'b1, 1'b0);
    stat_i = 3'b111; step();
    addr_en_n = 1'b0; iob_mode = 1'b0;

    // R11: code latched at start
    stat_i = 3'b110; step(); step();
    stat_i = 3'b001; step();
    chk("R11 type kept after status change", 7'b0110000, 1'b0, 1'b1, 1'b1);
    stat_i = 3'b111; step();

    // R6: abort right after start
    stat_i = 3'b101; step();
    stat_i = 3'b111; step();
    chk("R6 abort after first clock", 7'b0, 1'b0, 1'b0, 1'b1);

    // R3 / R5: back-to-back cycles
    stat_i = 3'b010; step();
    chk("R3 io write start", 7'b0, 1'b1, 1'b0, 1'b1);
    step();
    chk("R5 early io write only", 7'b0000010, 1'b0, 1'b1, 1'b1);
    stat_i = 3'b111; step();
    stat_i = 3'b000; step();
    chk("R3 back-to-back start", 7'b0, 1'b1, 1'b0, 1'b0);
    stat_i = 3'b111; step();
    chk("R6 idle after short ack", 7'b0, 1'b0, 1'b0, 1'b1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule